// File: doc/BRIEF.md
# Software Interrupt Target Decoder

This block sits behind the register write path of an interrupt distributor. When a CPU performs a full-word write to the software-interrupt trigger register, the block takes the write apart into two pieces: an interrupt number, and the set of CPUs that should see that interrupt become pending. It then sends a single set-pending request to the interrupt state bank.

The destination set is picked by a two-bit filter field carried in the written word. The filter can select an explicit CPU list taken from the data, every CPU except the writer, only the writer, or, for the reserved code, every CPU. The request is registered, so it appears one clock after the write is accepted. When the reserved code is used, a diagnostic flag is raised alongside the request for that one cycle.

Top module: `sgi_target_decoder`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, set_pend_o and rsvd_err_o are 0.
- R2: A write is accepted when wr_en_i is high, wr_addr_i equals the trigger offset (default 12'hF00) and all four byte strobes wr_be_i are set. For each accepted write, set_pend_o is high in the following cycle and set_id_o equals data bits 9:0.
- R3: With filter value 0 (data bits 25:24 = 2'b00), set_mask_o bit c equals data bit 16+c for each existing CPU c. List bits above the CPU count are ignored, and an empty list still issues the request with an all-zero mask.
- R4: With filter value 1, set_mask_o has every existing CPU bit set except bit wr_cpu_i.
- R5: With filter value 2, set_mask_o has only bit wr_cpu_i set.
- R6: With filter value 3 (reserved), set_mask_o has all existing CPU bits set.
- R7: A write to the trigger offset with any byte strobe clear produces no request.
- R8: A write to any other offset produces no request.
- R9: set_pend_o is high for exactly one cycle per accepted write. Writes accepted in consecutive cycles give requests in consecutive cycles, each with its own ID and mask.
- R10: rsvd_err_o is high in exactly the cycles where set_pend_o carries a reserved-filter request, and is low at all other times.
- R11: Data bits 15:10 and 31:26 have no effect on the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register byte offset |
| wr_be_i | input | 4 | Byte strobes of the write |
| wr_data_i | input | 32 | Write data |
| wr_cpu_i | input | 2 | Index of the writing CPU |
| set_pend_o | output | 1 | One-cycle set-pending request |
| set_id_o | output | 10 | Interrupt number to mark pending |
| set_mask_o | output | 4 | CPUs whose pending bit is set |
| rsvd_err_o | output | 1 | Reserved filter code was used |

## Verification
Two functions can fall in the same cycle. A reserved-filter request brings its error flag up together with the set-pending strobe. A write can also be accepted in the same cycle that the previous request is being presented, so the output register takes new contents while it is still driving the old ones. The bench provokes both cases with back-to-back accepted writes that alternate filters and writers, including reserved codes next to legal ones. The scoreboard then requires one request per write, in order, with the flag high only on the reserved entries and never between them.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ID_W     = 10;
  localparam int unsigned ID_LSB   = 0;
  localparam int unsigned LIST_LSB = 16;
  localparam int unsigned LIST_W   = 8;
  localparam int unsigned FILT_LSB = 24;

  typedef enum logic [1:0] {
    FILT_LIST   = 2'd0,
    FILT_OTHERS = 2'd1,
    FILT_SELF   = 2'd2,
    FILT_RSVD   = 2'd3
  } sgi_filt_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    sgi_filt_e         filt;
    logic [LIST_W-1:0] list;
  } sgi_fields_t;
endpackage

// File: rtl/sgi_wr_qualify.sv
module sgi_wr_qualify #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BE_W   = 4,
  parameter logic [ADDR_W-1:0] TRIG_OFFSET = 12'hF00
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              accept_o
);
  logic hit;
  logic full_word;

  assign hit       = (addr_i == TRIG_OFFSET);
  assign full_word = &be_i;
  assign accept_o  = wr_en_i && hit && full_word;
endmodule

// File: rtl/sgi_field_split.sv
module sgi_field_split
  import sgi_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output sgi_fields_t       fields_o
);
  localparam logic [DATA_W-1:0] USED_MASK =
    (DATA_W'((1 << ID_W) - 1) << ID_LSB) |
    (DATA_W'((1 << LIST_W) - 1) << LIST_LSB) |
    (DATA_W'(3) << FILT_LSB);

  logic unused_bits;

  assign fields_o.id   = data_i[ID_LSB +: ID_W];
  assign fields_o.list = data_i[LIST_LSB +: LIST_W];
  assign fields_o.filt = sgi_filt_e'(data_i[FILT_LSB +: 2]);
  // fields outside the decoded ones are don't-care
  assign unused_bits   = ^(data_i & ~USED_MASK);
endmodule

// File: rtl/sgi_dest_mask.sv
module sgi_dest_mask
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPU  = 4,
  localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  sgi_filt_e          filt_i,
  input  logic [LIST_W-1:0]  list_i,
  input  logic [CPU_W-1:0]   req_cpu_i,
  output logic [NUM_CPU-1:0] mask_o,
  output logic               rsvd_o
);
  logic [LIST_W-1:0] list_used;
  logic              unused_list;

  for (genvar c = 0; c < LIST_W; c++) begin : g_list
    if (c < NUM_CPU) begin : g_keep
      assign list_used[c] = list_i[c];
    end else begin : g_drop
      assign list_used[c] = 1'b0;
    end
  end
  assign unused_list = ^(list_i & ~list_used);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic is_req;
    logic list_bit;
    assign is_req = (req_cpu_i == CPU_W'(c));
    if (c < LIST_W) begin : g_lb
      assign list_bit = list_used[c];
    end else begin : g_nolb
      assign list_bit = 1'b0;
    end
    always_comb begin
      unique case (filt_i)
        FILT_LIST:   mask_o[c] = list_bit;
        FILT_OTHERS: mask_o[c] = !is_req;
        FILT_SELF:   mask_o[c] = is_req;
        default:     mask_o[c] = 1'b1;
      endcase
    end
  end

  assign rsvd_o = (filt_i == FILT_RSVD);
endmodule

// File: rtl/sgi_out_reg.sv
module sgi_out_reg
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic [ID_W-1:0]    id_i,
  input  logic [NUM_CPU-1:0] mask_i,
  input  logic               rsvd_i,
  output logic               pend_o,
  output logic [ID_W-1:0]    id_o,
  output logic [NUM_CPU-1:0] mask_o,
  output logic               err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      err_o  <= 1'b0;
      id_o   <= '0;
      mask_o <= '0;
    end else begin
      pend_o <= accept_i;
      err_o  <= accept_i && rsvd_i;
      if (accept_i) begin
        id_o   <= id_i;
        mask_o <= mask_i;
      end
    end
  end
endmodule

// File: rtl/sgi_target_decoder.sv
module sgi_target_decoder
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] TRIG_OFFSET = 12'hF00,
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [BE_W-1:0]    wr_be_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [CPU_W-1:0]   wr_cpu_i,
  output logic               set_pend_o,
  output logic [ID_W-1:0]    set_id_o,
  output logic [NUM_CPU-1:0] set_mask_o,
  output logic               rsvd_err_o
);
  logic               accept;
  sgi_fields_t        fields;
  logic [NUM_CPU-1:0] dest_mask;
  logic               rsvd;

  sgi_wr_qualify #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .TRIG_OFFSET(TRIG_OFFSET)
  ) u_qualify (
    .wr_en_i (wr_en_i),
    .addr_i  (wr_addr_i),
    .be_i    (wr_be_i),
    .accept_o(accept)
  );

  sgi_field_split u_split (
    .data_i  (wr_data_i),
    .fields_o(fields)
  );

  sgi_dest_mask #(.NUM_CPU(NUM_CPU)) u_dest (
    .filt_i   (fields.filt),
    .list_i   (fields.list),
    .req_cpu_i(wr_cpu_i),
    .mask_o   (dest_mask),
    .rsvd_o   (rsvd)
  );

  sgi_out_reg #(.NUM_CPU(NUM_CPU)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .id_i    (fields.id),
    .mask_i  (dest_mask),
    .rsvd_i  (rsvd),
    .pend_o  (set_pend_o),
    .id_o    (set_id_o),
    .mask_o  (set_mask_o),
    .err_o   (rsvd_err_o)
  );

  logic port_full_hit;
  logic [1:0] port_filt;
  assign port_full_hit = wr_en_i && (wr_addr_i == TRIG_OFFSET) && (&wr_be_i);
  assign port_filt     = wr_data_i[FILT_LSB +: 2];

  assert_pend_follows_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_full_hit |=> set_pend_o && (set_id_o == $past(wr_data_i[ID_LSB +: ID_W])));

  assert_narrow_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == TRIG_OFFSET) && !(&wr_be_i)) |=> !set_pend_o);

  assert_others_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_full_hit && port_filt == 2'd1) |=> ($countones(set_mask_o) == NUM_CPU - 1));

  assert_self_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_full_hit && port_filt == 2'd2) |=> ($countones(set_mask_o) == 1));

  assert_rsvd_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_full_hit && port_filt == 2'd3) |=> ((&set_mask_o) && rsvd_err_o));

  assert_err_with_pend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_err_o |-> set_pend_o);
endmodule

// File: tb/sgi_target_decoder_bench.sv
module sgi_target_decoder_bench;
  localparam int NCPU = 4;
  localparam logic [11:0] OFF = 12'hF00;

  typedef struct {
    logic [9:0]      id;
    logic [NCPU-1:0] mask;
    logic            err;
    string           req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [11:0] wr_addr_i = '0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  wr_cpu_i = '0;
  logic            set_pend_o;
  logic [9:0]      set_id_o;
  logic [NCPU-1:0] set_mask_o;
  logic            rsvd_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;
  exp_t sb[$];

  always #2 clk_i = ~clk_i;

  sgi_target_decoder #(.NUM_CPU(NCPU)) u_sgi_target_decoder (.*);

  function automatic logic [NCPU-1:0] exp_mask(logic [31:0] d, logic [1:0] cpu);
    case (d[25:24])
      2'd0:    return d[16 +: NCPU];
      2'd1:    return {NCPU{1'b1}} & ~(NCPU'(1) << cpu);
      2'd2:    return NCPU'(1) << cpu;
      default: return {NCPU{1'b1}};
    endcase
  endfunction

  function automatic logic [31:0] mk(logic [5:0] hi, logic [1:0] f, logic [7:0] lst,
                                     logic [5:0] mid, logic [9:0] id);
    return {hi, f, lst, mid, id};
  endfunction

  // driver: call at a negedge; drives one accepted write for one cycle
  task automatic wr_ok(logic [31:0] d, logic [1:0] cpu, string req);
    exp_t e;
    wr_en_i = 1'b1; wr_addr_i = OFF; wr_be_i = 4'hF; wr_data_i = d; wr_cpu_i = cpu;
    e.id = d[9:0]; e.mask = exp_mask(d, cpu); e.err = (d[25:24] == 2'd3); e.req = req;
    sb.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    wr_en_i = 1'b0; wr_be_i = '0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_ignored(logic [11:0] a, logic [3:0] be, logic [31:0] d, string req);
    wr_en_i = 1'b1; wr_addr_i = a; wr_be_i = be; wr_data_i = d; wr_cpu_i = 2'd1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = '0;
    checks++;
    if (set_pend_o !== 1'b0) begin
      errors++;
      $display("FAIL %s: set_pend_o=%b expected 0", req, set_pend_o);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (set_pend_o) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected set_pend_o=1 expected 0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (set_id_o !== e.id || set_mask_o !== e.mask || rsvd_err_o !== e.err) begin
            errors++;
            $display("FAIL %s: id=%h mask=%b err=%b expected id=%h mask=%b err=%b",
                     e.req, set_id_o, set_mask_o, rsvd_err_o, e.id, e.mask, e.err);
          end
        end
      end else if (rsvd_err_o !== 1'b0) begin
        checks++;
        errors++;
        $display("FAIL R10: rsvd_err_o=%b without request expected 0", rsvd_err_o);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run not finished expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (set_pend_o !== 1'b0 || rsvd_err_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: pend=%b err=%b expected 0 0", set_pend_o, rsvd_err_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (set_pend_o !== 1'b0 || rsvd_err_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: after release pend=%b err=%b expected 0 0", set_pend_o, rsvd_err_o);
    end
    mon_on = 1;

    // R2 R3 R11: list filter with junk in unused fields
    wr_ok(mk(6'h3F, 2'd0, 8'hA5, 6'h2A, 10'h3C7), 2'd2, "R3");
    idle(1);
    wr_ok(mk(6'h00, 2'd0, 8'hF0, 6'h00, 10'h001), 2'd0, "R3");   // high list bits only
    idle(1);
    wr_ok(mk(6'h15, 2'd0, 8'h0F, 6'h3F, 10'h3FF), 2'd3, "R11");
    idle(2);
    // R4 and R5 for every writer
    for (int c = 0; c < NCPU; c++) begin
      wr_ok(mk(6'h0, 2'd1, 8'h00, 6'h0, 10'(c + 5)), 2'(c), "R4");
      idle(1);
      wr_ok(mk(6'h0, 2'd2, 8'hFF, 6'h0, 10'(c + 9)), 2'(c), "R5");
      idle(1);
    end
    // R6 R10: reserved code
    wr_ok(mk(6'h2, 2'd3, 8'h00, 6'h1, 10'h155), 2'd1, "R6");
    idle(2);
    // R9 R10: back-to-back, mixing reserved with legal codes
    wr_ok(mk(6'h0, 2'd3, 8'h00, 6'h0, 10'h010), 2'd0, "R9");
    wr_ok(mk(6'h0, 2'd1, 8'h00, 6'h0, 10'h011), 2'd3, "R9");
    wr_ok(mk(6'h0, 2'd3, 8'h00, 6'h0, 10'h012), 2'd2, "R10");
    wr_ok(mk(6'h0, 2'd0, 8'h06, 6'h0, 10'h013), 2'd1, "R9");
    wr_ok(mk(6'h0, 2'd2, 8'h00, 6'h0, 10'h014), 2'd3, "R9");
    idle(2);
    // R7: narrow writes at the trigger offset
    wr_ignored(OFF, 4'b0011, mk(6'h0, 2'd3, 8'hFF, 6'h0, 10'h020), "R7");
    wr_ignored(OFF, 4'b1110, mk(6'h0, 2'd1, 8'hFF, 6'h0, 10'h021), "R7");
    wr_ignored(OFF, 4'b0001, mk(6'h0, 2'd0, 8'hFF, 6'h0, 10'h022), "R7");
    // R8: other offsets
    wr_ignored(12'hF04, 4'hF, mk(6'h0, 2'd2, 8'hFF, 6'h0, 10'h023), "R8");
    wr_ignored(12'h000, 4'hF, mk(6'h0, 2'd3, 8'hFF, 6'h0, 10'h024), "R8");
    idle(3);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d requests missing expected 0", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule